// File: doc/BRIEF.md
# Processor Power Mode Sequencer

This block steers a processor core between three operating states: run, where the core clock is active; idle, where the core is halted but interrupts are still watched; and sleep, where on-chip activity is shut down. Software asks for idle or sleep through request lines. An interrupt brings the core back from idle, and a wake-up event brings it back from sleep. A power-fault input forces the core into sleep from run or from idle.

Each mode change holds the block busy for a fixed time. That time is set per transition: 10 µs between run and idle in either direction, 90 µs into sleep, and 160 ms out of sleep. The times are turned into clock-cycle counts at elaboration, using a clock-frequency parameter and rounding up to at least one cycle.

While a change is in progress, the mode output already shows the destination, the core clock enable is held low, and every request input is ignored. A 2-bit power-level code reports the nominal draw of the mode that is shown: high for run (about 400 mW), medium for idle (about 50 mW) and minimal for sleep (about 160 µW).

Top module: `pmc_power_ctrl`

## Requirements
- R1: After reset, mode_o is run, core_clk_en_o is 1, busy_o is 0 and pwr_level_o is 2'b10.
- R2: mode_o is always one-hot, with bit 0 for run, bit 1 for idle and bit 2 for sleep. From the cycle after a request is accepted, it shows the destination mode.
- R3: core_clk_en_o is 1 only when the block is settled in run. It is 0 in idle, in sleep, and throughout any transition.
- R4: In settled run, idle_req_i moves the block to idle. busy_o stays high for ceil(CLK_HZ·10 µs) cycles, with a minimum of 1.
- R5: In settled idle, irq_i moves the block to run, with the same 10 µs latency.
- R6: In settled run, sleep_req_i moves the block to sleep. busy_o stays high for ceil(CLK_HZ·90 µs) cycles.
- R7: pwr_fault_i moves the block to sleep from settled run or settled idle, with the 90 µs latency. It outranks idle_req_i and irq_i.
- R8: In settled sleep, wake_i moves the block to run. busy_o stays high for ceil(CLK_HZ·160 ms) cycles.
- R9: While busy_o is 1, all request inputs are ignored. mode_o does not change until the transition completes.
- R10: In a settled mode, inputs that do not apply to that mode leave the state unchanged. These are wake_i and irq_i in run; idle_req_i and wake_i in idle; and idle_req_i, irq_i, sleep_req_i and pwr_fault_i in sleep.
- R11: pwr_level_o follows mode_o: 2'b10 for run, 2'b01 for idle and 2'b00 for sleep.
- R12: In settled run, sleep_req_i takes priority over idle_req_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_req_i | input | 1 | Software request to enter idle |
| sleep_req_i | input | 1 | Software request to enter sleep |
| irq_i | input | 1 | Interrupt line, leaves idle |
| pwr_fault_i | input | 1 | Power fault, forces sleep |
| wake_i | input | 1 | Wake-up event, leaves sleep |
| mode_o | output | 3 | One-hot mode (bit0 run, bit1 idle, bit2 sleep) |
| pwr_level_o | output | 2 | Nominal power-level code of the shown mode |
| core_clk_en_o | output | 1 | Core clock enable |
| busy_o | output | 1 | Transition in progress |

## Verification
The assertions check the following on every cycle:
- mode_o stays one-hot.
- The clock enable stays off whenever the block is busy or outside run.
- The power code matches the mode.
- mode_o does not move while busy.
- A settled mode reacts correctly to its next-cycle triggers, including fault priority.

The exact length of each transition is shown only by the bench's scenarios. That includes the 160 ms sleep exit, which is too long for a property window. The scenarios also show that inputs stay without effect across a whole busy window, and that a stale request has no effect after the window ends.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MODE_RUN   = 3'b001,
        MODE_IDLE  = 3'b010,
        MODE_SLEEP = 3'b100
    } pmc_mode_e;

    typedef enum logic [1:0] {
        LAT_SHORT     = 2'd0,
        LAT_SLEEP_IN  = 2'd1,
        LAT_SLEEP_OUT = 2'd2
    } pmc_lat_e;

    typedef enum logic [1:0] {
        PWR_MIN  = 2'b00,
        PWR_MID  = 2'b01,
        PWR_HIGH = 2'b10
    } pmc_pwr_e;

    typedef struct packed {
        pmc_mode_e mode;
        logic      busy;
        logic      clk_en;
    } pmc_state_t;

    // Round a duration in ns up to whole cycles at the given clock, minimum 1.
    function automatic longint unsigned pmc_cycles(longint unsigned hz,
                                                   longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/pmc_req_arbiter.sv
module pmc_req_arbiter
    import pmc_pkg::*;
(
    input  pmc_mode_e mode_i,
    input  logic      idle_req_i,
    input  logic      sleep_req_i,
    input  logic      irq_i,
    input  logic      pwr_fault_i,
    input  logic      wake_i,
    output logic      go_o,
    output pmc_mode_e target_o,
    output pmc_lat_e  lat_o
);

    always_comb begin
        go_o     = 1'b0;
        target_o = mode_i;
        lat_o    = LAT_SHORT;
        unique case (mode_i)
            MODE_RUN: begin
                if (pwr_fault_i || sleep_req_i) begin
                    go_o     = 1'b1;
                    target_o = MODE_SLEEP;
                    lat_o    = LAT_SLEEP_IN;
                end else if (idle_req_i) begin
                    go_o     = 1'b1;
                    target_o = MODE_IDLE;
                    lat_o    = LAT_SHORT;
                end
            end
            MODE_IDLE: begin
                if (pwr_fault_i || sleep_req_i) begin
                    go_o     = 1'b1;
                    target_o = MODE_SLEEP;
                    lat_o    = LAT_SLEEP_IN;
                end else if (irq_i) begin
                    go_o     = 1'b1;
                    target_o = MODE_RUN;
                    lat_o    = LAT_SHORT;
                end
            end
            MODE_SLEEP: begin
                if (wake_i) begin
                    go_o     = 1'b1;
                    target_o = MODE_RUN;
                    lat_o    = LAT_SLEEP_OUT;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pmc_lat_timer.sv
module pmc_lat_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pmc_pwr_encoder.sv
module pmc_pwr_encoder
    import pmc_pkg::*;
(
    input  pmc_mode_e mode_i,
    output pmc_pwr_e  pwr_o
);

    always_comb begin
        unique case (mode_i)
            MODE_RUN:   pwr_o = PWR_HIGH;
            MODE_IDLE:  pwr_o = PWR_MID;
            MODE_SLEEP: pwr_o = PWR_MIN;
            default:    pwr_o = PWR_MIN;
        endcase
    end

endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
    import pmc_pkg::*;
#(
    parameter longint unsigned CLK_HZ       = 100_000_000,
    parameter longint unsigned SHORT_NS     = 10_000,
    parameter longint unsigned SLEEP_IN_NS  = 90_000,
    parameter longint unsigned SLEEP_OUT_NS = 160_000_000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       idle_req_i,
    input  logic       sleep_req_i,
    input  logic       irq_i,
    input  logic       pwr_fault_i,
    input  logic       wake_i,
    output logic [2:0] mode_o,
    output logic [1:0] pwr_level_o,
    output logic       core_clk_en_o,
    output logic       busy_o
);

    localparam longint unsigned LAT_SHORT_C = pmc_cycles(CLK_HZ, SHORT_NS);
    localparam longint unsigned LAT_IN_C    = pmc_cycles(CLK_HZ, SLEEP_IN_NS);
    localparam longint unsigned LAT_OUT_C   = pmc_cycles(CLK_HZ, SLEEP_OUT_NS);
    localparam longint unsigned LAT_MAX_C   =
        (LAT_OUT_C > LAT_IN_C) ? ((LAT_OUT_C > LAT_SHORT_C) ? LAT_OUT_C : LAT_SHORT_C)
                               : ((LAT_IN_C > LAT_SHORT_C) ? LAT_IN_C : LAT_SHORT_C);
    localparam int CNT_W = $clog2(LAT_MAX_C + 1);

    pmc_state_t st_d, st_q;

    logic             arb_go;
    pmc_mode_e        arb_target;
    pmc_lat_e         arb_lat;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    pmc_pwr_e         pwr_code;

    pmc_req_arbiter i_arb (
        .mode_i      (st_q.mode),
        .idle_req_i  (idle_req_i),
        .sleep_req_i (sleep_req_i),
        .irq_i       (irq_i),
        .pwr_fault_i (pwr_fault_i),
        .wake_i      (wake_i),
        .go_o        (arb_go),
        .target_o    (arb_target),
        .lat_o       (arb_lat)
    );

    pmc_lat_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    pmc_pwr_encoder i_pwr (
        .mode_i (st_q.mode),
        .pwr_o  (pwr_code)
    );

    always_comb begin
        unique case (arb_lat)
            LAT_SLEEP_IN:  tmr_val = CNT_W'(LAT_IN_C);
            LAT_SLEEP_OUT: tmr_val = CNT_W'(LAT_OUT_C);
            default:       tmr_val = CNT_W'(LAT_SHORT_C);
        endcase
    end

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        if (st_q.busy) begin
            if (tmr_zero) begin
                st_d.busy   = 1'b0;
                st_d.clk_en = (st_q.mode == MODE_RUN);
            end
        end else if (arb_go) begin
            st_d.mode   = arb_target;
            st_d.busy   = 1'b1;
            st_d.clk_en = 1'b0;
            tmr_load    = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode   <= MODE_RUN;
            st_q.busy   <= 1'b0;
            st_q.clk_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o        = st_q.mode;
    assign busy_o        = st_q.busy;
    assign core_clk_en_o = st_q.clk_en;
    assign pwr_level_o   = pwr_code;

endmodule

// File: rtl/pmc_power_ctrl_chk.sv
module pmc_power_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       idle_req_i,
    input logic       sleep_req_i,
    input logic       irq_i,
    input logic       pwr_fault_i,
    input logic       wake_i,
    input logic [2:0] mode_o,
    input logic [1:0] pwr_level_o,
    input logic       core_clk_en_o,
    input logic       busy_o
);

    localparam logic [2:0] RUN   = 3'b001;
    localparam logic [2:0] IDLE  = 3'b010;
    localparam logic [2:0] SLEEP = 3'b100;

    a_r2_mode_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(mode_o) == 1);

    a_r3_clk_off_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !core_clk_en_o);

    a_r3_clk_off_outside_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o != RUN) |-> !core_clk_en_o);

    a_r3_clk_on_settled_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && mode_o == RUN) |-> core_clk_en_o);

    a_r9_mode_held_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(mode_o));

    a_r7_fault_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && mode_o == RUN && pwr_fault_i) |=> (busy_o && mode_o == SLEEP));

    a_r7_fault_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && mode_o == IDLE && pwr_fault_i) |=> (busy_o && mode_o == SLEEP));

    a_r5_irq_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && mode_o == IDLE && irq_i && !pwr_fault_i && !sleep_req_i)
        |=> (busy_o && mode_o == RUN));

    a_r4_idle_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && mode_o == RUN && idle_req_i && !sleep_req_i && !pwr_fault_i)
        |=> (busy_o && mode_o == IDLE));

    a_r10_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && mode_o == SLEEP && !wake_i) |=> (!busy_o && mode_o == SLEEP));

    a_r11_pwr_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == RUN) |-> (pwr_level_o == 2'b10));

    a_r11_pwr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == IDLE) |-> (pwr_level_o == 2'b01));

    a_r11_pwr_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == SLEEP) |-> (pwr_level_o == 2'b00));

endmodule

bind pmc_power_ctrl pmc_power_ctrl_chk i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .idle_req_i    (idle_req_i),
    .sleep_req_i   (sleep_req_i),
    .irq_i         (irq_i),
    .pwr_fault_i   (pwr_fault_i),
    .wake_i        (wake_i),
    .mode_o        (mode_o),
    .pwr_level_o   (pwr_level_o),
    .core_clk_en_o (core_clk_en_o),
    .busy_o        (busy_o)
);

// File: tb/test_pmc_power_ctrl.sv
module test_pmc_power_ctrl;

    localparam longint unsigned HZ = 200_000;
    localparam logic [2:0] RUN   = 3'b001;
    localparam logic [2:0] IDLE  = 3'b010;
    localparam logic [2:0] SLEEP = 3'b100;

    function automatic int to_cycles(longint unsigned ns);
        longint unsigned c;
        c = (HZ * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 1 : int'(c);
    endfunction

    localparam int L_SHORT = to_cycles(10_000);
    localparam int L_IN    = to_cycles(90_000);
    localparam int L_OUT   = to_cycles(160_000_000);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 1'b0, sleep_req = 1'b0, irq = 1'b0, fault = 1'b0, wake = 1'b0;
    logic [2:0] mode;
    logic [1:0] pwr;
    logic       clk_en, busy;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pmc_power_ctrl #(.CLK_HZ(HZ)) i_pmc_power_ctrl (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .idle_req_i    (idle_req),
        .sleep_req_i   (sleep_req),
        .irq_i         (irq),
        .pwr_fault_i   (fault),
        .wake_i        (wake),
        .mode_o        (mode),
        .pwr_level_o   (pwr),
        .core_clk_en_o (clk_en),
        .busy_o        (busy)
    );

    typedef struct {
        string      tag;
        logic [2:0] mode;
        logic       busy;
        logic       clk_en;
        logic [1:0] pwr;
    } exp_t;

    exp_t sb[$];

    function automatic logic [1:0] pwr_of(logic [2:0] m);
        return (m == RUN) ? 2'b10 : (m == IDLE) ? 2'b01 : 2'b00;
    endfunction

    // Expectation for the outputs after the coming rising edge.
    task automatic expect_next(string tag, logic [2:0] m, logic b, logic ce);
        exp_t e;
        e.tag = tag; e.mode = m; e.busy = b; e.clk_en = ce; e.pwr = pwr_of(m);
        sb.push_back(e);
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        idle_req = 1'b0; sleep_req = 1'b0; irq = 1'b0; fault = 1'b0; wake = 1'b0;
    endtask

    // Monitor: compare outputs against the queued expectations.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            vectors++;
            if (mode !== e.mode || busy !== e.busy || clk_en !== e.clk_en || pwr !== e.pwr) begin
                errors++;
                $display("FAIL %s: got mode=%b busy=%b clk_en=%b pwr=%b, expected mode=%b busy=%b clk_en=%b pwr=%b",
                         e.tag, mode, busy, clk_en, pwr, e.mode, e.busy, e.clk_en, e.pwr);
            end
        end
    end

    // Inputs are already set; follow the transition to its end.
    task automatic transition(string tag, logic [2:0] target, int lat, bit noise);
        expect_next(tag, target, 1'b1, 1'b0);
        tick();
        clear_inputs();
        for (int i = 1; i < lat; i++) begin
            if (noise) begin
                wake = 1'b1; irq = 1'b1; idle_req = 1'b1; sleep_req = 1'b1;
            end
            expect_next({tag, " busy window"}, target, 1'b1, 1'b0);
            tick();
        end
        clear_inputs();
        expect_next({tag, " settle"}, target, 1'b0, target == RUN);
        tick();
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        expect_next("R1 reset state", RUN, 1'b0, 1'b1);
        tick();

        // R10 wake and irq in run are ignored
        wake = 1'b1; irq = 1'b1;
        expect_next("R10 wake/irq in run", RUN, 1'b0, 1'b1);
        tick();
        clear_inputs();

        // R4 run to idle, R2 target shown, R3 clock off, R11 code
        idle_req = 1'b1;
        transition("R4 run->idle", IDLE, L_SHORT, 1'b0);

        // R10 idle_req and wake in idle ignored
        idle_req = 1'b1; wake = 1'b1;
        expect_next("R10 idle_req/wake in idle", IDLE, 1'b0, 1'b0);
        tick();
        clear_inputs();

        // R5 interrupt leaves idle
        irq = 1'b1;
        transition("R5 idle->run", RUN, L_SHORT, 1'b0);

        // R12 sleep over idle priority, R6 latency, R9 noise while busy
        sleep_req = 1'b1; idle_req = 1'b1;
        transition("R12 R6 R9 run->sleep", SLEEP, L_IN, 1'b1);

        // R10 in sleep: idle_req, irq, sleep_req, fault ignored
        idle_req = 1'b1; irq = 1'b1; sleep_req = 1'b1; fault = 1'b1;
        expect_next("R10 requests in sleep", SLEEP, 1'b0, 1'b0);
        tick();
        clear_inputs();
        expect_next("R10 sleep held", SLEEP, 1'b0, 1'b0);
        tick();

        // R8 long sleep exit
        wake = 1'b1;
        transition("R8 sleep->run", RUN, L_OUT, 1'b0);

        // R7 fault from run, outranking idle_req
        fault = 1'b1; idle_req = 1'b1;
        transition("R7 fault run->sleep", SLEEP, L_IN, 1'b0);

        wake = 1'b1;
        transition("R8 second exit", RUN, L_OUT, 1'b1);

        // R7 fault from idle, outranking irq
        idle_req = 1'b1;
        transition("R4 run->idle again", IDLE, L_SHORT, 1'b0);
        fault = 1'b1; irq = 1'b1;
        transition("R7 fault idle->sleep", SLEEP, L_IN, 1'b0);

        repeat (2) tick();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule